// File: doc/BRIEF.md
# Write-Only Key Store

This block keeps the secret keys that the block-cipher and keyed-hash engines use. Each key slot is loaded word by word, either over a small register bus or over a data channel. A slot hands its key to its engine only after the slot holds every word its algorithm needs. Key words can never be read back: a bus read of any key word address returns zero. The configuration and error registers can be read.

Each slot first gets an algorithm code. Changing a slot's code wipes the slot, so words from two keys are never mixed. A channel write is accepted only from the channel that is assigned to the current use case. For the tweakable storage mode, the block compares the two key halves once the pair is complete. If the halves are equal, it throws the pair away. Two sticky error bits report dropped writes and rejected pairs. Software clears them by writing one to them. Reset wipes every slot.

Top module: `wo_key_store`

## Requirements
- R1: While reset is low and right after it, `key_valid`, `key_o`, `err_o` and `bus_rdata` are all zero, and every slot's algorithm code is 0 (none). Asserting reset at any time wipes all loaded keys.
- R2: A bus read of any key word address (from `KEY_WORDS` up to `KEY_WORDS*(NUM_SLOTS+1)-1`, with word i of slot s at `KEY_WORDS*(1+s)+i`) returns zero on `bus_rdata` one cycle later, even when the slot holds a valid key.
- R3: Address s (for s below `NUM_SLOTS`) is slot s's configuration register. A write stores the algorithm code from data bits [2:0]: 0 none, 1 AES-128, 2 AES-256, 3 XTS-128, 4 XTS-256, 5 HMAC-512. A read returns the code in bits [2:0] and the slot's valid flag in bit 8.
- R4: With 32-bit words, a slot needs words 0..3 for AES-128, 0..7 for AES-256 and XTS-128, and 0..15 for XTS-256 and HMAC-512. The slot's `key_valid` bit rises one cycle after the edge that stores the last missing word. Word i of slot s is driven on `key_o[(s*KEY_WORDS+i)*32 +: 32]` only while the slot is valid; otherwise that field is zero.
- R5: A key word write whose index is at or beyond the number of words the slot's algorithm needs (this includes every index when the code is none) is dropped and sets `err_o[0]`.
- R6: A channel write is stored in slot `chan_id` only when `chan_id` equals `chan_sel`. Otherwise it is dropped and sets `err_o[0]`.
- R7: When an XTS slot is complete and its first half equals its second half, the slot is wiped (all words and progress cleared), its valid bit stays low and `err_o[1]` is set. Distinct halves validate normally.
- R8: Writing a code that differs from the slot's current code wipes the slot's words, progress and valid bit. Writing the same code changes nothing.
- R9: A word write into a valid slot clears its valid bit at that edge, and the slot re-validates one cycle later.
- R10: Address `NUM_SLOTS` is the error register (bit 0 dropped write, bit 1 rejected XTS pair). Writing one to a bit clears it. If a new error event occurs in the same cycle as the clear, the bit stays set.
- R11: When the bus and the channel both write the same slot in one cycle, only the bus write is stored.
- R12: A configuration write with code 6 or 7 is ignored (the slot keeps its code) and sets `err_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; wipes all keys |
| bus_we | input | 1 | Register bus write strobe |
| bus_re | input | 1 | Register bus read strobe |
| bus_addr | input | AW | Register bus word address |
| bus_wdata | input | DW | Register bus write data |
| bus_rdata | output | DW | Read data, registered, valid one cycle after `bus_re` |
| chan_sel | input | CW | Channel assigned to the current use case |
| chan_we | input | 1 | Channel key word write strobe |
| chan_id | input | CW | Channel issuing the write; channel k feeds slot k |
| chan_widx | input | IW | Word index within the slot |
| chan_wdata | input | DW | Channel key word |
| key_o | output | NUM_SLOTS*KEY_WORDS*DW | Keys for the engines, zero while a slot is not valid |
| key_valid | output | NUM_SLOTS | Per-slot complete-key flag |
| err_o | output | 2 | Sticky errors: bit 0 dropped write, bit 1 rejected XTS pair |

## Verification
Two functions can land in the same cycle: an error event that raises a sticky bit, and a software write-one-clear of that bit. The bench provokes this by driving a channel write from a non-assigned channel in the same cycle as a clear write to the error register. It passes if `err_o[0]` is still set afterward and a later clear with no event removes it. The other collision is a bus write and a channel write to the same word of one slot in the same cycle. That case passes if the validated key shows the bus value.

// File: rtl/ks_pkg.sv
package ks_pkg;

   typedef enum logic [2:0] {
      ALG_NONE    = 3'd0,
      ALG_AES128  = 3'd1,
      ALG_AES256  = 3'd2,
      ALG_XTS128  = 3'd3,
      ALG_XTS256  = 3'd4,
      ALG_HMAC512 = 3'd5
   } alg_e;

   localparam logic [2:0] ALG_LAST = 3'd5;

   // words needed for a key, given words per 128 bits
   function automatic int need_words(alg_e a, int blk_words);
      case (a)
         ALG_AES128:              return blk_words;
         ALG_AES256, ALG_XTS128:  return 2 * blk_words;
         ALG_XTS256, ALG_HMAC512: return 4 * blk_words;
         default:                 return 0;
      endcase
   endfunction

   function automatic logic is_xts(alg_e a);
      return (a == ALG_XTS128) || (a == ALG_XTS256);
   endfunction

endpackage

// File: rtl/ks_xts_cmp.sv
module ks_xts_cmp #(
   parameter int DW        = 32,
   parameter int KEY_WORDS = 16,
   localparam int IW       = $clog2(KEY_WORDS),
   localparam int PAIRS    = KEY_WORDS / 2
) (
   input  logic [KEY_WORDS-1:0][DW-1:0] words_i,
   input  logic [IW-1:0]                half_i,
   output logic                         equal_o
);

   logic [PAIRS-1:0] match;

   for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      logic [IW-1:0] partner;
      assign partner  = IW'(i) + half_i;
      assign match[i] = (IW'(i) >= half_i) || (words_i[i] == words_i[partner]);
   end

   assign equal_o = (half_i != '0) && (&match);

endmodule

// File: rtl/ks_route.sv
module ks_route import ks_pkg::*; #(
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int NUM_SLOTS = 2,
   parameter int KEY_WORDS = 16,
   localparam int CW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int IW       = $clog2(KEY_WORDS),
   localparam int SW       = AW - IW
) (
   input  logic                                bus_we,
   input  logic [AW-1:0]                       bus_addr,
   input  logic [DW-1:0]                       bus_wdata,
   input  logic                                chan_we,
   input  logic [CW-1:0]                       chan_id,
   input  logic [IW-1:0]                       chan_widx,
   input  logic [DW-1:0]                       chan_wdata,
   input  logic [CW-1:0]                       chan_sel,
   output logic [NUM_SLOTS-1:0]                slot_we,
   output logic [NUM_SLOTS-1:0][IW-1:0]        slot_idx,
   output logic [NUM_SLOTS-1:0][DW-1:0]        slot_data,
   output logic [NUM_SLOTS-1:0]                cfg_we,
   output alg_e                                cfg_alg,
   output logic [1:0]                          err_clr,
   output logic                                blk_o
);

   localparam int KEY_BASE = KEY_WORDS;
   localparam int KEY_END  = KEY_WORDS * (NUM_SLOTS + 1);
   localparam int ERR_ADDR = NUM_SLOTS;
   localparam int CW1      = CW + 1;

   logic          key_hit, cfg_hit, code_ok, chan_ok;
   logic [AW-1:0] key_off;
   logic [SW-1:0] bus_slot;
   logic [IW-1:0] bus_widx;

   assign key_hit  = bus_we && (bus_addr >= AW'(KEY_BASE)) && (bus_addr < AW'(KEY_END));
   assign key_off  = bus_addr - AW'(KEY_BASE);
   assign bus_slot = key_off[AW-1:IW];
   assign bus_widx = key_off[IW-1:0];
   assign cfg_hit  = bus_we && (bus_addr < AW'(NUM_SLOTS));
   assign code_ok  = bus_wdata[2:0] <= ALG_LAST;
   assign cfg_alg  = alg_e'(bus_wdata[2:0]);
   assign chan_ok  = chan_we && (chan_id == chan_sel) && ({1'b0, chan_id} < CW1'(NUM_SLOTS));
   assign blk_o    = (chan_we && !chan_ok) || (cfg_hit && !code_ok);
   assign err_clr  = (bus_we && bus_addr == AW'(ERR_ADDR)) ? bus_wdata[1:0] : 2'b00;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic bus_s, chan_s;
      assign bus_s        = key_hit && (bus_slot == SW'(s));
      assign chan_s       = chan_ok && (chan_id == CW'(s));
      assign slot_we[s]   = bus_s || chan_s;
      assign slot_idx[s]  = bus_s ? bus_widx  : chan_widx;
      assign slot_data[s] = bus_s ? bus_wdata : chan_wdata;
      assign cfg_we[s]    = cfg_hit && code_ok && (bus_addr == AW'(s));
   end

endmodule

// File: rtl/ks_slot.sv
module ks_slot import ks_pkg::*; #(
   parameter int DW        = 32,
   parameter int KEY_WORDS = 16,
   localparam int IW       = $clog2(KEY_WORDS),
   localparam int BLK      = 128 / DW
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we_i,
   input  alg_e                         cfg_alg_i,
   input  logic                         wr_en_i,
   input  logic [IW-1:0]                wr_idx_i,
   input  logic [DW-1:0]                wr_data_i,
   output alg_e                         alg_o,
   output logic                         valid_o,
   output logic [KEY_WORDS-1:0][DW-1:0] key_o,
   output logic                         range_err_o,
   output logic                         reject_o
);

   alg_e                         alg_q;
   logic                         valid_q;
   logic [KEY_WORDS-1:0]         mask_q;
   logic [KEY_WORDS-1:0][DW-1:0] word_q;

   int                   need;
   logic [KEY_WORDS-1:0] need_mask;
   logic [IW-1:0]        half;
   logic                 cfg_chg, wr_ok, complete, chk, halves_eq;

   always_comb begin
      need = need_words(alg_q, BLK);
      for (int i = 0; i < KEY_WORDS; i++) need_mask[i] = (i < need);
      half = IW'(need / 2);
   end

   assign cfg_chg     = cfg_we_i && (cfg_alg_i != alg_q);
   assign range_err_o = wr_en_i && !need_mask[wr_idx_i];
   assign wr_ok       = wr_en_i && need_mask[wr_idx_i] && !cfg_chg;
   assign complete    = (alg_q != ALG_NONE) && ((mask_q & need_mask) == need_mask);
   assign chk         = complete && !valid_q && !cfg_chg && !wr_ok;
   assign reject_o    = chk && is_xts(alg_q) && halves_eq;

   ks_xts_cmp #(.DW(DW), .KEY_WORDS(KEY_WORDS)) u_cmp (
      .words_i (word_q),
      .half_i  (half),
      .equal_o (halves_eq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alg_q   <= ALG_NONE;
         valid_q <= 1'b0;
         mask_q  <= '0;
         word_q  <= '0;
      end else if (cfg_chg) begin
         alg_q   <= cfg_alg_i;
         valid_q <= 1'b0;
         mask_q  <= '0;
         word_q  <= '0;
      end else if (reject_o) begin
         valid_q <= 1'b0;
         mask_q  <= '0;
         word_q  <= '0;
      end else if (wr_ok) begin
         word_q[wr_idx_i] <= wr_data_i;
         mask_q[wr_idx_i] <= 1'b1;
         valid_q          <= 1'b0;
      end else if (chk) begin
         valid_q <= 1'b1;
      end
   end

   assign alg_o   = alg_q;
   assign valid_o = valid_q;
   assign key_o   = valid_q ? word_q : '0;

   AST_VALID_COVERS_NEED: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (alg_q != ALG_NONE) && ((mask_q & need_mask) == need_mask)); // R4
   AST_REJECT_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      reject_o |=> (mask_q == '0) && !valid_q && (word_q == '0)); // R7
   AST_ALG_SWAP_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> (mask_q == '0) && !valid_q && (word_q == '0)); // R8
   AST_REWRITE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && valid_q) |=> !valid_q); // R9

endmodule

// File: rtl/wo_key_store.sv
module wo_key_store import ks_pkg::*; #(
   parameter int DW        = 32,
   parameter int NUM_SLOTS = 2,
   parameter int KEY_WORDS = 16,
   parameter int AW        = 8,
   localparam int CW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int IW       = $clog2(KEY_WORDS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_we,
   input  logic                              bus_re,
   input  logic [AW-1:0]                     bus_addr,
   input  logic [DW-1:0]                     bus_wdata,
   output logic [DW-1:0]                     bus_rdata,
   input  logic [CW-1:0]                     chan_sel,
   input  logic                              chan_we,
   input  logic [CW-1:0]                     chan_id,
   input  logic [IW-1:0]                     chan_widx,
   input  logic [DW-1:0]                     chan_wdata,
   output logic [NUM_SLOTS*KEY_WORDS*DW-1:0] key_o,
   output logic [NUM_SLOTS-1:0]              key_valid,
   output logic [1:0]                        err_o
);

   localparam int ERR_ADDR = NUM_SLOTS;
   localparam int KEY_END  = KEY_WORDS * (NUM_SLOTS + 1);

   if (!(DW == 32 || DW == 64)) begin : g_bad_dw
      $error("wo_key_store: DW must be 32 or 64");
   end
   if (KEY_WORDS < 512 / DW || (KEY_WORDS & (KEY_WORDS - 1)) != 0) begin : g_bad_kw
      $error("wo_key_store: KEY_WORDS must be a power of two holding 512 bits");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS >= KEY_WORDS) begin : g_bad_ns
      $error("wo_key_store: NUM_SLOTS out of range");
   end
   if (KEY_END >= (1 << AW)) begin : g_bad_aw
      $error("wo_key_store: AW too small for the address map");
   end

   logic [NUM_SLOTS-1:0]                    slot_we, cfg_we, slot_rng, slot_rej;
   logic [NUM_SLOTS-1:0][IW-1:0]            slot_idx;
   logic [NUM_SLOTS-1:0][DW-1:0]            slot_data;
   logic [NUM_SLOTS-1:0][KEY_WORDS-1:0][DW-1:0] slot_key;
   alg_e                                    slot_alg [NUM_SLOTS];
   alg_e                                    cfg_alg;
   logic [1:0]                              err_clr, err_q, err_set;
   logic                                    route_blk;
   logic [DW-1:0]                           rd_val;

   ks_route #(.DW(DW), .AW(AW), .NUM_SLOTS(NUM_SLOTS), .KEY_WORDS(KEY_WORDS)) u_route (
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .chan_we    (chan_we),
      .chan_id    (chan_id),
      .chan_widx  (chan_widx),
      .chan_wdata (chan_wdata),
      .chan_sel   (chan_sel),
      .slot_we    (slot_we),
      .slot_idx   (slot_idx),
      .slot_data  (slot_data),
      .cfg_we     (cfg_we),
      .cfg_alg    (cfg_alg),
      .err_clr    (err_clr),
      .blk_o      (route_blk)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      ks_slot #(.DW(DW), .KEY_WORDS(KEY_WORDS)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .cfg_we_i    (cfg_we[s]),
         .cfg_alg_i   (cfg_alg),
         .wr_en_i     (slot_we[s]),
         .wr_idx_i    (slot_idx[s]),
         .wr_data_i   (slot_data[s]),
         .alg_o       (slot_alg[s]),
         .valid_o     (key_valid[s]),
         .key_o       (slot_key[s]),
         .range_err_o (slot_rng[s]),
         .reject_o    (slot_rej[s])
      );
   end

   assign key_o = slot_key;

   // sticky errors: a new event wins over a clear in the same cycle
   assign err_set = {|slot_rej, route_blk | (|slot_rng)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 2'b00;
      else        err_q <= err_set | (err_q & ~err_clr);
   end
   assign err_o = err_q;

   // key words read back as zero; only config and error are visible
   always_comb begin
      rd_val = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (bus_addr == AW'(s)) rd_val = DW'({key_valid[s], 5'b00000, slot_alg[s]});
      end
      if (bus_addr == AW'(ERR_ADDR)) rd_val = DW'(err_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_val;
      else             bus_rdata <= '0;
   end

   logic key_rd;
   assign key_rd = bus_re && (bus_addr >= AW'(KEY_WORDS)) && (bus_addr < AW'(KEY_END));

   AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      key_rd |=> (bus_rdata == '0)); // R2
   AST_CFG_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cfg_we)); // R3
   AST_FOREIGN_CHAN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_we && chan_id != chan_sel) |=> err_q[0]); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q[0] && !err_clr[0]) |=> err_q[0]); // R10
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      err_set[0] |=> err_q[0]); // R10

endmodule

// File: tb/wo_key_store_bench.sv
`timescale 1ns/1ps
module wo_key_store_bench;
   localparam int DW = 32, NS = 2, KW = 16, AW = 8;

   logic              clk = 1'b0, rst_n = 1'b0;
   logic              bus_we = 1'b0, bus_re = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [DW-1:0]     bus_wdata = '0, bus_rdata;
   logic              chan_sel = 1'b0, chan_we = 1'b0, chan_id = 1'b0;
   logic [3:0]        chan_widx = '0;
   logic [DW-1:0]     chan_wdata = '0;
   logic [NS*KW*DW-1:0] key_o;
   logic [NS-1:0]     key_valid;
   logic [1:0]        err_o;

   wo_key_store #(.DW(DW), .NUM_SLOTS(NS), .KEY_WORDS(KW), .AW(AW)) u_wo_key_store (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_sel(chan_sel), .chan_we(chan_we),
      .chan_id(chan_id), .chan_widx(chan_widx), .chan_wdata(chan_wdata), .key_o(key_o),
      .key_valid(key_valid), .err_o(err_o));

   always #4 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data and compares
   always @(posedge clk) rd_seen <= bus_re && rst_n;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) chk("R2 unexpected read", 64'(bus_rdata), 64'hDEAD);
         else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, 64'(bus_rdata), 64'(e));
         end
      end
   end

   function automatic logic [31:0] kw(int s, int i);
      return key_o[(s*KW+i)*DW +: DW];
   endfunction

   task automatic bus_wr(logic [7:0] a, logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic key_wr(int s, int i, logic [31:0] d);
      bus_wr(8'(KW + s*KW + i), d);
   endtask

   task automatic chan_wr(logic id, logic [3:0] i, logic [31:0] d);
      chan_we = 1'b1; chan_id = id; chan_widx = i; chan_wdata = d;
      @(negedge clk);
      chan_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] e, string t);
      exp_q.push_back(e); tag_q.push_back(t);
      bus_re = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", 64'(key_valid), 64'd0);
      chk("R1 err in reset", 64'(err_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 key_o after reset", 64'(|key_o), 64'd0);
      rd(8'd0, 32'h0, "R1 cfg0 after reset");

      // R3 / R4: AES-128 in slot 0
      bus_wr(8'd0, 32'd1);
      rd(8'd0, 32'h1, "R3 cfg0 code");
      for (int i = 0; i < 4; i++) key_wr(0, i, 32'hA000_0000 + 32'(i));
      chk("R4 not valid at completing edge", 64'(key_valid[0]), 64'd0);
      @(negedge clk);
      chk("R4 valid one cycle later", 64'(key_valid[0]), 64'd1);
      chk("R4 word0", 64'(kw(0, 0)), 64'hA000_0000);
      chk("R4 word3", 64'(kw(0, 3)), 64'hA000_0003);
      rd(8'd0, 32'h101, "R3 cfg0 valid bit");

      // R2: key words read as zero
      rd(8'd16, 32'h0, "R2 read slot0 word0");
      rd(8'd19, 32'h0, "R2 read slot0 word3");

      // R5: index beyond need
      key_wr(0, 4, 32'h5555_5555);
      chk("R5 range error", 64'(err_o), 64'd1);
      chk("R5 word4 untouched", 64'(kw(0, 4)), 64'd0);
      chk("R5 still valid", 64'(key_valid[0]), 64'd1);

      // R10: clear, then set and clear in the same cycle
      bus_wr(8'd2, 32'd1);
      chk("R10 w1c", 64'(err_o), 64'd0);
      chan_sel = 1'b0;
      chan_we = 1'b1; chan_id = 1'b1; chan_widx = 4'd0; chan_wdata = 32'h1;
      bus_we = 1'b1; bus_addr = 8'd2; bus_wdata = 32'd1;
      @(negedge clk);
      chan_we = 1'b0; bus_we = 1'b0;
      chk("R10 set beats clear", 64'(err_o), 64'd1);
      bus_wr(8'd2, 32'd1);
      chk("R10 cleared", 64'(err_o), 64'd0);

      // R6: HMAC via channel 1
      chan_sel = 1'b1;
      bus_wr(8'd1, 32'd5);
      for (int i = 0; i < 16; i++) chan_wr(1'b1, 4'(i), 32'hC000_0000 + 32'(i));
      @(negedge clk);
      chk("R6 hmac valid", 64'(key_valid[1]), 64'd1);
      chk("R6 hmac word15", 64'(kw(1, 15)), 64'hC000_000F);
      chan_sel = 1'b0;
      chan_wr(1'b1, 4'd0, 32'hBAD0_BAD0);
      chk("R6 foreign channel flagged", 64'(err_o), 64'd1);
      chk("R6 foreign write dropped", 64'(kw(1, 0)), 64'hC000_0000);
      bus_wr(8'd2, 32'd1);

      // R9: assigned channel rewrites a valid slot
      chan_wr(1'b0, 4'd2, 32'hD000_0002);
      chk("R9 valid dropped", 64'(key_valid[0]), 64'd0);
      @(negedge clk);
      chk("R9 revalidated", 64'(key_valid[0]), 64'd1);
      chk("R6 accepted word", 64'(kw(0, 2)), 64'hD000_0002);

      // R8: code change wipes progress
      bus_wr(8'd0, 32'd2);
      chk("R8 valid cleared", 64'(key_valid[0]), 64'd0);
      for (int i = 4; i < 8; i++) key_wr(0, i, 32'hE000_0000 + 32'(i));
      @(negedge clk);
      chk("R8 old words not kept", 64'(key_valid[0]), 64'd0);
      for (int i = 0; i < 4; i++) key_wr(0, i, 32'hE000_0000 + 32'(i));
      @(negedge clk);
      chk("R8 aes256 valid", 64'(key_valid[0]), 64'd1);
      bus_wr(8'd0, 32'd2);
      chk("R8 same code keeps key", 64'(kw(0, 7)), 64'hE000_0007);

      // R7: equal XTS halves
      bus_wr(8'd0, 32'd3);
      for (int i = 0; i < 8; i++) key_wr(0, i, 32'h7700_0000 + 32'(i % 4));
      @(negedge clk);
      chk("R7 reject flag", 64'(err_o), 64'd2);
      chk("R7 not valid", 64'(key_valid[0]), 64'd0);
      for (int i = 0; i < 4; i++) key_wr(0, i, 32'h7700_0000 + 32'(i));
      @(negedge clk);
      chk("R7 pair wiped", 64'(key_valid[0]), 64'd0);
      for (int i = 4; i < 8; i++) key_wr(0, i, 32'h8800_0000 + 32'(i));
      @(negedge clk);
      chk("R7 distinct halves valid", 64'(key_valid[0]), 64'd1);
      chk("R7 word5", 64'(kw(0, 5)), 64'h8800_0005);
      bus_wr(8'd2, 32'd2);

      // R11: bus and channel collide on slot 0 word 0
      bus_wr(8'd0, 32'd1);
      chan_we = 1'b1; chan_id = 1'b0; chan_widx = 4'd0; chan_wdata = 32'hCCCC_CCCC;
      bus_we = 1'b1; bus_addr = 8'd16; bus_wdata = 32'hBBBB_BBBB;
      @(negedge clk);
      chan_we = 1'b0; bus_we = 1'b0;
      for (int i = 1; i < 4; i++) key_wr(0, i, 32'h1100_0000 + 32'(i));
      @(negedge clk);
      chk("R11 valid", 64'(key_valid[0]), 64'd1);
      chk("R11 bus wins", 64'(kw(0, 0)), 64'hBBBB_BBBB);

      // R12: bad code
      bus_wr(8'd0, 32'd7);
      chk("R12 flagged", 64'(err_o), 64'd1);
      rd(8'd0, 32'h101, "R12 code kept");

      // R1: reset mid-run wipes keys
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset valid", 64'(key_valid), 64'd0);
      chk("R1 reset key_o", 64'(|key_o), 64'd0);
      chk("R1 reset err", 64'(err_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'd1, 32'h0, "R1 cfg1 after reset");
      @(negedge clk);
      chk("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule